// File: doc/BRIEF.md
# Dual-Channel Wiper and Data Register Bank

This block keeps the register state behind a two-channel digital potentiometer. Each channel has a volatile 6-bit wiper register that picks one of 64 tap positions, plus four 6-bit data registers that stand in for non-volatile cells. A serial front end decodes each frame and hands the bank one command per cycle. It also sends a strobe when chip select rises at the end of the frame, and a strobe when a frame is abandoned. The bank drives the wiper positions straight out. It answers read commands on a registered read port. It shows a write-in-process flag while a modelled non-volatile write is running.

Changes to data registers are staged. A command that would alter a data register captures its value and target into a pending slot, but the registers keep their old contents. The new contents take effect only when the chip-select-rise strobe arrives. That strobe also starts a write-busy timer of `WRITE_CYCLES` clocks. While the timer runs, further data-register writes are dropped. Reads and wiper-only commands are still served. `por_ni` stands for a loss of power and sets every data register to `DR_INIT`. `rst_ni` resets only the volatile state, and on the first clock after it releases, each wiper reloads from its channel's data register 0.

Top module: `pot_reg_bank`

## Requirements
- R1: On the first clock edge after `rst_ni` is released, each wiper loads its own channel's data register 0. `wip_o` is 0 after reset. Data register contents survive an `rst_ni` pulse.
- R2: While `por_ni` is low, every data register of every channel is set to `DR_INIT`.
- R3: Code 1 (write wiper) sets the addressed channel's wiper to `cmd_data_i`. Code 0 (read wiper) returns the current wiper value. The other channel is left unchanged.
- R4: Code 8 (step) moves the addressed wiper by one. `cmd_data_i[0]`=1 steps up and 0 steps down. The value stays at 63 going up and at 0 going down, with no wrap.
- R5: Code 4 copies data register `cmd_idx_i` of the addressed channel into that channel's wiper in the same cycle.
- R6: Code 6 copies data register `cmd_idx_i` of every channel into that channel's wiper at once.
- R7: Codes 3 (write data register from `cmd_data_i`), 5 (store the addressed wiper) and 7 (store all wipers) capture their values at command time. Code 2 (read data register) keeps returning the old value until `cs_rise_i`. `frame_abort_i` discards the pending change.
- R8: A commit raises `wip_o` for exactly `WRITE_CYCLES` clock cycles. Code 9 (status) returns `wip_o` in bit 0 and zeros in all other bits.
- R9: While `wip_o` is 1, codes 3, 5 and 7 are ignored and a following `cs_rise_i` changes nothing. Reads and the wiper codes still take effect.
- R10: `rd_valid_o` is high for exactly the one cycle that follows an accepted read command (codes 0, 2, 9), with the data on `rd_data_o`. It is low at all other times.
- R11: Codes 5 and 7 write the wiper values held at command time into data register `cmd_idx_i`, of the addressed channel or of all channels.
- R12: Codes 10 to 15 change no state and produce no read response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of volatile state |
| por_ni | input | 1 | Asynchronous active-low power-on reset of the data registers |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 4 | Operation code (see R3 to R12) |
| cmd_ch_i | input | $clog2(NUM_CH) | Addressed channel |
| cmd_idx_i | input | $clog2(NUM_DR) | Data register index |
| cmd_data_i | input | DATA_W | Write value; bit 0 is the step direction |
| cs_rise_i | input | 1 | End-of-frame strobe that commits the pending write |
| frame_abort_i | input | 1 | Discards the pending write |
| wiper_o | output | NUM_CH*DATA_W | Wiper positions, channel 0 in the low bits |
| rd_data_o | output | DATA_W | Read response data |
| rd_valid_o | output | 1 | Read response strobe |
| wip_o | output | 1 | Write-in-process flag |

## Verification
The bench builds the bank with `WRITE_CYCLES` = 16 and `DR_INIT` = 21. With the short write time, the exact edges where the busy window opens and closes can be checked cycle by cycle, and several commit, wait and re-commit rounds fit in a short run. Because `DR_INIT` is not zero, the reload from data register 0 is visible on the wiper outputs. After a `rst_ni`-only pulse, a committed value must reappear on one channel, while the other channel still shows the power-on value.

// File: rtl/pot_bank_pkg.sv
package pot_bank_pkg;
  typedef enum logic [3:0] {
    OP_RD_WIPER      = 4'd0,
    OP_WR_WIPER      = 4'd1,
    OP_RD_DR         = 4'd2,
    OP_WR_DR         = 4'd3,
    OP_DR_TO_WIPER   = 4'd4,
    OP_WIPER_TO_DR   = 4'd5,
    OP_G_DR_TO_WIPER = 4'd6,
    OP_G_WIPER_TO_DR = 4'd7,
    OP_STEP          = 4'd8,
    OP_RD_STATUS     = 4'd9
  } cmd_op_e;
endpackage

// File: rtl/pot_nv_timer.sv
module pot_nv_timer #(
  parameter int unsigned CYCLES = 250000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(CYCLES - 1);
      end
    end else if (cnt_q == '0) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;

  assert_busy_needs_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(start_i));
  assert_busy_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != '0) |=> busy_q);
endmodule

// File: rtl/pot_channel.sv
module pot_channel #(
  parameter int unsigned DATA_W = 6,
  parameter int unsigned NUM_DR = 4,
  parameter logic [DATA_W-1:0] DR_INIT = '0,
  localparam int unsigned IDX_W = $clog2(NUM_DR)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic              reload_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_val_i,
  input  logic              step_en_i,
  input  logic              step_up_i,
  input  logic              commit_i,
  input  logic [IDX_W-1:0]  commit_idx_i,
  input  logic [DATA_W-1:0] commit_val_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] dr_rd_o,
  output logic [DATA_W-1:0] wiper_o
);
  localparam logic [DATA_W-1:0] MAX_POS = '1;

  logic [DATA_W-1:0] dr_q [NUM_DR];
  logic [DATA_W-1:0] wiper_q;
  logic [DATA_W-1:0] step_val;

  for (genvar i = 0; i < NUM_DR; i++) begin : g_dr
    always_ff @(posedge clk_i or negedge por_ni) begin
      if (!por_ni)                                    dr_q[i] <= DR_INIT;
      else if (commit_i && commit_idx_i == IDX_W'(i)) dr_q[i] <= commit_val_i;
    end

    assert_dr_only_on_commit_R7: assert property (@(posedge clk_i) disable iff (!por_ni)
      !commit_i |=> $stable(dr_q[i]));
  end

  always_comb begin
    if (step_up_i) step_val = (wiper_q == MAX_POS) ? MAX_POS : wiper_q + 1'b1;
    else           step_val = (wiper_q == '0) ? '0 : wiper_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        wiper_q <= '0;
    else if (reload_i)  wiper_q <= dr_q[0];
    else if (wr_en_i)   wiper_q <= wr_val_i;
    else if (step_en_i) wiper_q <= step_val;
  end

  assign dr_rd_o = dr_q[rd_idx_i];
  assign wiper_o = wiper_q;

  assert_reload_dr0_R1: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    reload_i |=> wiper_q == $past(dr_q[0]));
  assert_step_sat_top_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_en_i && step_up_i && !reload_i && !wr_en_i && wiper_q == MAX_POS) |=> wiper_q == MAX_POS);
  assert_step_sat_bot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_en_i && !step_up_i && !reload_i && !wr_en_i && wiper_q == '0) |=> wiper_q == '0);
endmodule

// File: rtl/pot_reg_bank.sv
module pot_reg_bank
  import pot_bank_pkg::*;
#(
  parameter int unsigned NUM_CH       = 2,
  parameter int unsigned NUM_DR       = 4,
  parameter int unsigned DATA_W       = 6,
  parameter int unsigned WRITE_CYCLES = 250000,
  parameter logic [DATA_W-1:0] DR_INIT = '0,
  localparam int unsigned CH_W  = $clog2(NUM_CH),
  localparam int unsigned IDX_W = $clog2(NUM_DR)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     por_ni,
  input  logic                     cmd_valid_i,
  input  logic [3:0]               cmd_op_i,
  input  logic [CH_W-1:0]          cmd_ch_i,
  input  logic [IDX_W-1:0]         cmd_idx_i,
  input  logic [DATA_W-1:0]        cmd_data_i,
  input  logic                     cs_rise_i,
  input  logic                     frame_abort_i,
  output logic [NUM_CH*DATA_W-1:0] wiper_o,
  output logic [DATA_W-1:0]        rd_data_o,
  output logic                     rd_valid_o,
  output logic                     wip_o
);
  cmd_op_e           op;
  logic              load_q;
  logic              cmd_fire;
  logic              is_nv_wr;
  logic              is_rd;
  logic              capture;
  logic              commit_go;
  logic              wip;
  logic              pend_vld_q;
  logic [IDX_W-1:0]  pend_idx_q;
  logic [DATA_W-1:0] wiper_w [NUM_CH];
  logic [DATA_W-1:0] dr_rd_w [NUM_CH];
  logic [DATA_W-1:0] rd_data_q;
  logic [DATA_W-1:0] rd_next;
  logic              rd_valid_q;

  assign op       = cmd_op_e'(cmd_op_i);
  assign cmd_fire = cmd_valid_i && !load_q;
  assign is_nv_wr = (op == OP_WR_DR) || (op == OP_WIPER_TO_DR) || (op == OP_G_WIPER_TO_DR);
  assign is_rd    = (op == OP_RD_WIPER) || (op == OP_RD_DR) || (op == OP_RD_STATUS);
  assign capture  = cmd_fire && is_nv_wr && !wip;
  assign commit_go = cs_rise_i && pend_vld_q && !wip;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) load_q <= 1'b1;
    else         load_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_vld_q <= 1'b0;
      pend_idx_q <= '0;
    end else if (capture) begin
      pend_vld_q <= 1'b1;
      pend_idx_q <= cmd_idx_i;
    end else if (cs_rise_i || frame_abort_i) begin
      pend_vld_q <= 1'b0;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic              hit;
    logic              wr_en;
    logic [DATA_W-1:0] wr_val;
    logic              step_en;
    logic              pmask_q;
    logic [DATA_W-1:0] pval_q;

    assign hit = (cmd_ch_i == CH_W'(c));

    always_comb begin
      wr_en   = 1'b0;
      wr_val  = cmd_data_i;
      step_en = 1'b0;
      if (cmd_fire) begin
        case (op)
          OP_WR_WIPER:      wr_en = hit;
          OP_DR_TO_WIPER:   begin wr_en = hit;  wr_val = dr_rd_w[c]; end
          OP_G_DR_TO_WIPER: begin wr_en = 1'b1; wr_val = dr_rd_w[c]; end
          OP_STEP:          step_en = hit;
          default:          ;
        endcase
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pmask_q <= 1'b0;
        pval_q  <= '0;
      end else if (capture) begin
        pmask_q <= hit || (op == OP_G_WIPER_TO_DR);
        pval_q  <= (op == OP_WR_DR) ? cmd_data_i : wiper_w[c];
      end
    end

    pot_channel #(
      .DATA_W (DATA_W),
      .NUM_DR (NUM_DR),
      .DR_INIT(DR_INIT)
    ) u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .por_ni      (por_ni),
      .reload_i    (load_q),
      .wr_en_i     (wr_en),
      .wr_val_i    (wr_val),
      .step_en_i   (step_en),
      .step_up_i   (cmd_data_i[0]),
      .commit_i    (commit_go && pmask_q),
      .commit_idx_i(pend_idx_q),
      .commit_val_i(pval_q),
      .rd_idx_i    (cmd_idx_i),
      .dr_rd_o     (dr_rd_w[c]),
      .wiper_o     (wiper_w[c])
    );

    assign wiper_o[c*DATA_W +: DATA_W] = wiper_w[c];
  end

  pot_nv_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(commit_go),
    .busy_o (wip)
  );

  always_comb begin
    case (op)
      OP_RD_WIPER: rd_next = wiper_w[cmd_ch_i];
      OP_RD_DR:    rd_next = dr_rd_w[cmd_ch_i];
      default:     rd_next = {{(DATA_W-1){1'b0}}, wip};
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= cmd_fire && is_rd;
      if (cmd_fire && is_rd) rd_data_q <= rd_next;
    end
  end

  assign rd_data_o  = rd_data_q;
  assign rd_valid_o = rd_valid_q;
  assign wip_o      = wip;

  assert_no_pending_while_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wip |-> !pend_vld_q);
  assert_read_answers_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_fire && is_rd) |=> rd_valid_o);
  assert_no_spurious_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_fire && is_rd) |=> !rd_valid_o);
endmodule

// File: tb/pot_reg_bank_tb.sv
module pot_reg_bank_tb;
  import pot_bank_pkg::*;

  localparam int unsigned NUM_CH = 2;
  localparam int unsigned NUM_DR = 4;
  localparam int unsigned DATA_W = 6;
  localparam int unsigned WCYC   = 16;
  localparam logic [5:0]  INIT   = 6'd21;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        por_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd_op = '0;
  logic        cmd_ch = 1'b0;
  logic [1:0]  cmd_idx = '0;
  logic [5:0]  cmd_data = '0;
  logic        cs_rise = 1'b0;
  logic        abort = 1'b0;
  logic [11:0] wiper;
  logic [5:0]  rd_data;
  logic        rd_valid;
  logic        wip;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pot_reg_bank #(
    .NUM_CH(NUM_CH), .NUM_DR(NUM_DR), .DATA_W(DATA_W),
    .WRITE_CYCLES(WCYC), .DR_INIT(INIT)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_ch_i(cmd_ch),
    .cmd_idx_i(cmd_idx), .cmd_data_i(cmd_data),
    .cs_rise_i(cs_rise), .frame_abort_i(abort),
    .wiper_o(wiper), .rd_data_o(rd_data), .rd_valid_o(rd_valid), .wip_o(wip)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cmd(cmd_op_e op, int ch, int idx, int data);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_ch = ch[0];
    cmd_idx = idx[1:0]; cmd_data = data[5:0];
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic raw_op(int code);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = code[3:0]; cmd_data = 6'd1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic strobe_cs();
    @(negedge clk); cs_rise = 1'b1;
    @(negedge clk); cs_rise = 1'b0;
  endtask

  task automatic strobe_abort();
    @(negedge clk); abort = 1'b1;
    @(negedge clk); abort = 1'b0;
  endtask

  task automatic read_chk(string req, cmd_op_e op, int ch, int idx, int exp);
    cmd(op, ch, idx, 0);
    chk({req, " rd_valid"}, rd_valid, 1);
    chk(req, rd_data, exp);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && wip; i++) @(negedge clk);
    chk("R8 busy ends", wip, 0);
  endtask

  task automatic t_reset();
    por_n = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    chk("R1 wip after reset", wip, 0);
    chk("R1 R2 wiper0 reload", wiper[5:0], INIT);
    chk("R1 R2 wiper1 reload", wiper[11:6], INIT);
    chk("R10 no read valid idle", rd_valid, 0);
    read_chk("R2 dr init", OP_RD_DR, 1, 3, INIT);
  endtask

  task automatic t_wiper_write();
    cmd(OP_WR_WIPER, 0, 0, 10);
    chk("R3 wiper0 written", wiper[5:0], 10);
    chk("R3 wiper1 untouched", wiper[11:6], INIT);
    cmd(OP_WR_WIPER, 1, 0, 50);
    read_chk("R3 read wiper1", OP_RD_WIPER, 1, 0, 50);
    @(negedge clk);
    chk("R10 valid one cycle", rd_valid, 0);
  endtask

  task automatic t_step();
    cmd(OP_WR_WIPER, 0, 0, 62);
    cmd(OP_STEP, 0, 0, 1);
    chk("R4 step up", wiper[5:0], 63);
    cmd(OP_STEP, 0, 0, 1);
    cmd(OP_STEP, 0, 0, 1);
    chk("R4 saturate at 63", wiper[5:0], 63);
    cmd(OP_WR_WIPER, 1, 0, 1);
    cmd(OP_STEP, 1, 0, 0);
    chk("R4 step down", wiper[11:6], 0);
    cmd(OP_STEP, 1, 0, 0);
    chk("R4 saturate at 0", wiper[11:6], 0);
    chk("R4 other channel held", wiper[5:0], 63);
  endtask

  task automatic t_deferred();
    cmd(OP_WR_DR, 0, 2, 45);
    read_chk("R7 old value before commit", OP_RD_DR, 0, 2, INIT);
    strobe_abort();
    strobe_cs();
    chk("R7 abort no busy", wip, 0);
    read_chk("R7 abort discards", OP_RD_DR, 0, 2, INIT);
    cmd(OP_WR_DR, 0, 2, 45);
    strobe_cs();
    chk("R8 wip rises at commit", wip, 1);
    repeat (WCYC - 1) @(negedge clk);
    chk("R8 wip still high at last cycle", wip, 1);
    @(negedge clk);
    chk("R8 wip low after window", wip, 0);
    read_chk("R7 value after commit", OP_RD_DR, 0, 2, 45);
    read_chk("R8 status idle", OP_RD_STATUS, 0, 0, 0);
  endtask

  task automatic t_busy();
    cmd(OP_WR_DR, 1, 1, 9);
    strobe_cs();
    cmd(OP_WR_DR, 1, 1, 7);
    strobe_cs();
    read_chk("R8 status busy", OP_RD_STATUS, 0, 0, 1);
    cmd(OP_WR_WIPER, 1, 0, 33);
    chk("R9 wiper write while busy", wiper[11:6], 33);
    read_chk("R9 read while busy", OP_RD_DR, 1, 1, 9);
    wait_idle();
    strobe_cs();
    chk("R9 no late commit", wip, 0);
    read_chk("R9 ignored write lost", OP_RD_DR, 1, 1, 9);
  endtask

  task automatic t_xfer();
    cmd(OP_DR_TO_WIPER, 0, 2, 0);
    chk("R5 dr to wiper0", wiper[5:0], 45);
    chk("R5 wiper1 untouched", wiper[11:6], 33);
    cmd(OP_WIPER_TO_DR, 1, 3, 0);
    cmd(OP_WR_WIPER, 1, 0, 2);
    strobe_cs();
    wait_idle();
    read_chk("R11 wiper1 stored at cmd time", OP_RD_DR, 1, 3, 33);
    read_chk("R11 ch0 idx3 untouched", OP_RD_DR, 0, 3, INIT);
  endtask

  task automatic t_global();
    cmd(OP_WR_WIPER, 0, 0, 5);
    cmd(OP_WR_WIPER, 1, 0, 6);
    cmd(OP_G_WIPER_TO_DR, 0, 1, 0);
    strobe_cs();
    wait_idle();
    read_chk("R11 global store ch0", OP_RD_DR, 0, 1, 5);
    read_chk("R11 global store ch1", OP_RD_DR, 1, 1, 6);
    cmd(OP_WR_WIPER, 0, 0, 0);
    cmd(OP_WR_WIPER, 1, 0, 0);
    cmd(OP_G_DR_TO_WIPER, 1, 1, 0);
    chk("R6 global load ch0", wiper[5:0], 5);
    chk("R6 global load ch1", wiper[11:6], 6);
  endtask

  task automatic t_illegal();
    for (int code = 10; code < 16; code++) begin
      raw_op(code);
      chk("R12 no read response", rd_valid, 0);
    end
    chk("R12 wiper0 held", wiper[5:0], 5);
    chk("R12 wiper1 held", wiper[11:6], 6);
    strobe_cs();
    chk("R12 no write started", wip, 0);
  endtask

  task automatic t_retention();
    cmd(OP_WR_DR, 1, 0, 40);
    strobe_cs();
    wait_idle();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reload ch1 from committed dr0", wiper[11:6], 40);
    chk("R1 reload ch0 from dr0", wiper[5:0], INIT);
    read_chk("R1 dr kept across reset", OP_RD_DR, 0, 2, 45);
  endtask

  initial begin
    t_reset();
    t_wiper_write();
    t_step();
    t_deferred();
    t_busy();
    t_xfer();
    t_global();
    t_illegal();
    t_retention();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule